// File: doc/BRIEF.md
# Dual-Mode Multiplexed Bus Slave Interface

This block sits between an 8-bit multiplexed address/data bus and a 128-byte map made of time bytes, four control registers and user RAM. A static mode input picks one of two strobe styles. In the first style, a data strobe is qualified by a read/write level. In the second style, separate active-low read and write strobes are used. An address strobe demultiplexes the bus. The falling edge of the address strobe captures a 7-bit address, and the next rising edge invalidates that address. Accesses take place only while chip-select is low and the power-fail input is inactive.

All strobes are asynchronous to the system clock. They pass through two-flop synchronizers and edge detectors, and the data bus is delayed by the same amount so that it stays aligned with them. The block gives the memory array a one-cycle write pulse with address, data and a per-bit writable mask. It drives read data back through a separate output bus with an output-enable. When a read of the interrupt status register completes, it sends a one-cycle pulse to the interrupt logic so that the flags there can be cleared.

Top module: `mbus_slave`

## Requirements
- R1: With `mode_i`=1, a cycle with `rw_i` low while `ds_i` is high is a write. On the falling edge of `ds_i`, exactly one `mem_we_o` pulse of one cycle is issued, carrying the latched address and the data held on `ad_i` while the strobe was high.
- R2: With `mode_i`=0, a low pulse on `rw_i` (active-low write) is a write. It is committed with one `mem_we_o` pulse at the rising edge of `rw_i`.
- R3: With `mode_i`=1, `ad_oe_o` is high while `ds_i` and `rw_i` are both high, and `ad_o` then equals `mem_rdata_i`. A write and an output-enable never coincide.
- R4: With `mode_i`=0, `ad_oe_o` is high while `ds_i` (active-low read) is low. It falls again after `ds_i` returns high.
- R5: On the falling edge of `as_i`, the address is taken from `ad_i[6:0]` and appears on `mem_addr_o`. On the rising edge of `as_i`, the address is marked invalid, so a strobe that occurs while `as_i` stays high performs no access.
- R6: A cycle with `cs_ni` high still latches the address, but it produces no write pulse and no output-enable.
- R7: The writable mask depends on the address. Address 0 gives 8'h7F. Address 10 gives 8'h7F. Addresses 12 and 13 are not writable at all, so no write pulse is issued for them. Every other address gives 8'hFF.
- R8: When a read of address 12 completes, `rdc_pulse_o` is high for one cycle at the trailing edge of the read strobe. A read of any other address produces no such pulse.
- R9: While `rst_ni` is low, or while `pfail_i` is high, `ad_oe_o` stays low and no write or read-clear pulse is produced.
- R10: A strobe edge takes effect on the second rising clock edge after the edge is applied. Before that, the output is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | 1: data strobe + read/write level; 0: separate active-low read/write |
| cs_ni | input | 1 | Active-low chip select |
| as_i | input | 1 | Address strobe, address taken on falling edge |
| ds_i | input | 1 | Data strobe (mode 1) or active-low read (mode 0) |
| rw_i | input | 1 | Read/write level (mode 1) or active-low write (mode 0) |
| pfail_i | input | 1 | Power-fail, blocks all access while high |
| ad_i | input | 8 | Multiplexed bus, input side |
| ad_o | output | 8 | Multiplexed bus, output side |
| ad_oe_o | output | 1 | Output-enable for ad_o |
| mem_addr_o | output | 7 | Latched address to the map |
| mem_we_o | output | 1 | One-cycle write pulse |
| mem_wdata_o | output | 8 | Write data |
| mem_wmask_o | output | 8 | Writable-bit mask for the current address |
| mem_rdata_i | input | 8 | Read data from the map |
| rdc_pulse_o | output | 1 | One-cycle pulse when a read of address 12 completes |

## Verification
The write pulse, the read-clear pulse and the output-enable all appear two rising clock edges after the strobe edge that causes them. The latched address follows one edge later than that. The bench applies stimulus at falling clock edges and holds each bus phase for at least four cycles before it samples. One directed test samples the write pulse one cycle after a data-strobe edge, where the pulse must still be low, and again two cycles after that edge, where it must be high. Pulses are counted by a monitor that samples on the falling clock edge, so each one-cycle pulse is seen exactly once.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  localparam int ADDR_W      = 7;
  localparam int DATA_W      = 8;
  localparam int SYNC_STAGES = 2;

  localparam logic [ADDR_W-1:0] ADR_SEC  = 7'd0;
  localparam logic [ADDR_W-1:0] ADR_CTLA = 7'd10;
  localparam logic [ADDR_W-1:0] ADR_STAT = 7'd12;
  localparam logic [ADDR_W-1:0] ADR_VALD = 7'd13;
endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] q_prev_o
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [W-1:0]             prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q  <= {STAGES{RST_VAL}};
      prev_q <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign q_o      = stg_q[STAGES-1];
  assign q_prev_o = prev_q;
endmodule

// File: rtl/mbus_strobe.sv
module mbus_strobe (
  input  logic mode_i,
  input  logic ds_q_i,
  input  logic ds_p_i,
  input  logic rw_q_i,
  input  logic rw_p_i,
  output logic rd_win_o,
  output logic rd_end_o,
  output logic wr_end_o
);
  always_comb begin
    if (mode_i) begin
      // strobe + direction level
      rd_win_o = ds_q_i & rw_q_i;
      rd_end_o = ds_p_i & ~ds_q_i & rw_p_i;
      wr_end_o = ds_p_i & ~ds_q_i & ~rw_p_i;
    end else begin
      // separate active-low read / write
      rd_win_o = ~ds_q_i;
      rd_end_o = ~ds_p_i & ds_q_i;
      wr_end_o = ~rw_p_i & rw_q_i;
    end
  end
endmodule

// File: rtl/mbus_decode.sv
module mbus_decode
  import mbus_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] wmask_o,
  output logic              is_stat_o
);
  logic ro_reg;
  logic top_locked;

  assign ro_reg     = (addr_i == ADR_STAT) || (addr_i == ADR_VALD);
  assign top_locked = (addr_i == ADR_SEC)  || (addr_i == ADR_CTLA);
  assign is_stat_o  = (addr_i == ADR_STAT);

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b == DATA_W-1) begin : g_msb
      assign wmask_o[b] = ~ro_reg & ~top_locked;
    end else begin : g_low
      assign wmask_o[b] = ~ro_reg;
    end
  end
endmodule

// File: rtl/mbus_slave.sv
module mbus_slave
  import mbus_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              cs_ni,
  input  logic              as_i,
  input  logic              ds_i,
  input  logic              rw_i,
  input  logic              pfail_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [DATA_W-1:0] mem_wmask_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              rdc_pulse_o
);
  localparam int CTL_W = 4;  // {as, ds, rw, cs_n}

  logic [CTL_W-1:0]  ctl_q, ctl_p;
  logic [DATA_W-1:0] dat_q, dat_p;

  mbus_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(4'b0011)) u_ctl_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .d_i     ({as_i, ds_i, rw_i, cs_ni}),
    .q_o     (ctl_q),
    .q_prev_o(ctl_p)
  );

  // data delayed alongside strobes; prev stage = last sample inside strobe
  mbus_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_dat_dly (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .d_i     (ad_i),
    .q_o     (dat_q),
    .q_prev_o(dat_p)
  );

  logic as_q, as_p, ds_q, ds_p, rw_q, rw_p, cs_q, cs_p;
  assign {as_q, ds_q, rw_q, cs_q} = ctl_q;
  assign {as_p, ds_p, rw_p, cs_p} = ctl_p;

  logic rd_win, rd_end, wr_end;

  mbus_strobe u_strobe (
    .mode_i  (mode_i),
    .ds_q_i  (ds_q),
    .ds_p_i  (ds_p),
    .rw_q_i  (rw_q),
    .rw_p_i  (rw_p),
    .rd_win_o(rd_win),
    .rd_end_o(rd_end),
    .wr_end_o(wr_end)
  );

  logic [ADDR_W-1:0] addr_q;
  logic              addr_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q     <= '0;
      addr_vld_q <= 1'b0;
    end else if (as_p && !as_q) begin
      addr_q     <= dat_p[ADDR_W-1:0];
      addr_vld_q <= 1'b1;
    end else if (!as_p && as_q) begin
      addr_vld_q <= 1'b0;
    end
  end

  logic [DATA_W-1:0] wmask;
  logic              is_stat;

  mbus_decode u_decode (
    .addr_i   (addr_q),
    .wmask_o  (wmask),
    .is_stat_o(is_stat)
  );

  logic live_now, live_end;
  assign live_now = addr_vld_q & ~cs_q & ~pfail_i;
  assign live_end = addr_vld_q & ~cs_p & ~pfail_i;  // cs as seen inside strobe

  assign ad_oe_o     = rd_win & live_now;
  assign ad_o        = ad_oe_o ? mem_rdata_i : '0;
  assign mem_addr_o  = addr_q;
  assign mem_wmask_o = wmask;
  assign mem_wdata_o = dat_p;
  assign mem_we_o    = wr_end & live_end & (|wmask);
  assign rdc_pulse_o = rd_end & live_end & is_stat;
endmodule

// File: rtl/mbus_slave_chk.sv
module mbus_slave_chk
  import mbus_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pfail_i,
  input logic              ad_oe_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_we_o,
  input logic [DATA_W-1:0] mem_wmask_o,
  input logic              rdc_pulse_o
);
  a_r1_we_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);

  a_r2_we_not_during_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !ad_oe_o);

  a_r5_addr_stable_in_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ad_oe_o && $past(ad_oe_o)) |-> $stable(mem_addr_o));

  a_r7_no_we_readonly: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !(mem_addr_o == ADR_STAT || mem_addr_o == ADR_VALD));

  a_r7_msb_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && (mem_addr_o == ADR_SEC || mem_addr_o == ADR_CTLA)) |-> !mem_wmask_o[DATA_W-1]);

  a_r8_rdc_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdc_pulse_o |=> !rdc_pulse_o);

  a_r8_rdc_only_stat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdc_pulse_o |-> mem_addr_o == ADR_STAT);

  a_r9_pfail_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pfail_i |-> !(ad_oe_o || mem_we_o || rdc_pulse_o));
endmodule

bind mbus_slave mbus_slave_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pfail_i    (pfail_i),
  .ad_oe_o    (ad_oe_o),
  .mem_addr_o (mem_addr_o),
  .mem_we_o   (mem_we_o),
  .mem_wmask_o(mem_wmask_o),
  .rdc_pulse_o(rdc_pulse_o)
);

// File: tb/mbus_slave_test.sv
module mbus_slave_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_i = 1'b1, cs_ni = 1'b1, as_i = 1'b0, ds_i = 1'b0, rw_i = 1'b1, pfail_i = 1'b0;
  logic [7:0] ad_i = '0, ad_o, mem_wdata_o, mem_wmask_o, mem_rdata_i;
  logic [6:0] mem_addr_o;
  logic       ad_oe_o, mem_we_o, rdc_pulse_o;

  always #2 clk_i = ~clk_i;  // 250 MHz

  assign mem_rdata_i = {1'b0, mem_addr_o} ^ 8'hA5;

  mbus_slave uut (.*);

  int tests = 0, fails = 0;
  int we_cnt = 0, rdc_cnt = 0;
  logic [6:0] cap_addr;
  logic [7:0] cap_data, cap_mask;

  always @(negedge clk_i) begin
    if (mem_we_o) begin
      we_cnt++; cap_addr = mem_addr_o; cap_data = mem_wdata_o; cap_mask = mem_wmask_o;
    end
    if (rdc_pulse_o) rdc_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // one bus cycle; samples oe/data mid-strobe and oe after strobe end
  task automatic cyc(input bit md, input bit sel, input bit wr, input logic [6:0] a,
                     input logic [7:0] d, input bit hold_as,
                     output bit oe_mid, output logic [7:0] rd_mid, output bit oe_after);
    mode_i = md; ds_i = md ? 1'b0 : 1'b1; rw_i = 1'b1;
    cs_ni = ~sel; ad_i = {1'b0, a}; as_i = 1'b1;
    wt(4);
    if (!hold_as) as_i = 1'b0;
    wt(4);
    ad_i = d;
    if (md) begin rw_i = ~wr; ds_i = 1'b1; end
    else if (wr) rw_i = 1'b0;
    else ds_i = 1'b0;
    wt(5);
    oe_mid = ad_oe_o; rd_mid = ad_o;
    ds_i = md ? 1'b0 : 1'b1; rw_i = 1'b1;
    wt(5);
    oe_after = ad_oe_o;
    cs_ni = 1'b1; as_i = 1'b0;
    wt(4);
  endtask

  // {mode, addr, data, mask, we_expected}
  localparam logic [24:0] VEC [8] = '{
    {1'b1, 7'd0,   8'hFF, 8'h7F, 1'b1},
    {1'b0, 7'd5,   8'h3C, 8'hFF, 1'b1},
    {1'b1, 7'd10,  8'hAA, 8'h7F, 1'b1},
    {1'b0, 7'd12,  8'h55, 8'h00, 1'b0},
    {1'b1, 7'd13,  8'h11, 8'h00, 1'b0},
    {1'b0, 7'd127, 8'hC3, 8'hFF, 1'b1},
    {1'b1, 7'd12,  8'h5A, 8'h00, 1'b0},
    {1'b0, 7'd11,  8'h81, 8'hFF, 1'b1}
  };

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit oe_m, oe_a;
    logic [7:0] rdv;
    int w0, r0;

    wt(3);
    chk(ad_oe_o == 0 && mem_we_o == 0 && rdc_pulse_o == 0, "R9 reset outputs idle", ad_oe_o, 0);
    // R9: strobes under reset do nothing
    cyc(1'b1, 1'b1, 1'b0, 7'd20, 8'h00, 1'b0, oe_m, rdv, oe_a);
    chk(oe_m == 0, "R9 no oe in reset", oe_m, 0);
    rst_ni = 1'b1;
    wt(4);

    for (int i = 0; i < 8; i++) begin
      logic [24:0] v = VEC[i];
      w0 = we_cnt; r0 = rdc_cnt;
      cyc(v[24], 1'b1, 1'b1, v[23:17], v[16:9], 1'b0, oe_m, rdv, oe_a);
      chk(we_cnt - w0 == int'(v[0]), v[24] ? "R1 write count" : "R2 write count", we_cnt - w0, v[0]);
      if (v[0]) begin
        chk(cap_addr == v[23:17] && cap_data == v[16:9], "R5 write addr/data", {cap_addr, cap_data}, {v[23:17], v[16:9]});
        chk(cap_mask == v[8:1], "R7 write mask", cap_mask, v[8:1]);
      end
      chk(oe_m == 0, "R3 no oe during write", oe_m, 0);
      r0 = rdc_cnt;
      cyc(v[24], 1'b1, 1'b0, v[23:17], 8'h00, 1'b0, oe_m, rdv, oe_a);
      chk(oe_m == 1 && rdv == ({1'b0, v[23:17]} ^ 8'hA5), v[24] ? "R3 read data" : "R4 read data",
          rdv, {1'b0, v[23:17]} ^ 8'hA5);
      chk(oe_a == 0, "R4 oe released", oe_a, 0);
      chk(rdc_cnt - r0 == int'(v[23:17] == 7'd12), "R8 read-clear pulse", rdc_cnt - r0, v[23:17] == 7'd12);
    end

    // R6: no chip select -> no access, address still latched
    w0 = we_cnt;
    cyc(1'b1, 1'b0, 1'b1, 7'd33, 8'h77, 1'b0, oe_m, rdv, oe_a);
    chk(we_cnt == w0, "R6 no write without cs", we_cnt - w0, 0);
    chk(mem_addr_o == 7'd33, "R6 address latched without cs", mem_addr_o, 33);
    r0 = rdc_cnt;
    cyc(1'b0, 1'b0, 1'b0, 7'd12, 8'h00, 1'b0, oe_m, rdv, oe_a);
    chk(oe_m == 0 && rdc_cnt == r0, "R6 no read without cs", oe_m, 0);

    // R5: AS held high -> address discarded, no access
    w0 = we_cnt;
    cyc(1'b0, 1'b1, 1'b1, 7'd40, 8'h66, 1'b1, oe_m, rdv, oe_a);
    chk(we_cnt == w0, "R5 strobe with AS high ignored", we_cnt - w0, 0);

    // R9: power-fail blocks read and write
    pfail_i = 1'b1;
    w0 = we_cnt; r0 = rdc_cnt;
    cyc(1'b1, 1'b1, 1'b1, 7'd50, 8'h12, 1'b0, oe_m, rdv, oe_a);
    chk(we_cnt == w0, "R9 no write under pfail", we_cnt - w0, 0);
    cyc(1'b1, 1'b1, 1'b0, 7'd12, 8'h00, 1'b0, oe_m, rdv, oe_a);
    chk(oe_m == 0 && rdc_cnt == r0, "R9 no read under pfail", oe_m, 0);
    pfail_i = 1'b0;

    // R10: latency of write pulse from DS trailing edge
    mode_i = 1'b1; ds_i = 1'b0; rw_i = 1'b1; cs_ni = 1'b0; ad_i = 8'd20; as_i = 1'b1;
    wt(4); as_i = 1'b0; wt(4);
    ad_i = 8'h9E; rw_i = 1'b0; ds_i = 1'b1; wt(5);
    ds_i = 1'b0;
    @(posedge clk_i); @(negedge clk_i);
    chk(mem_we_o == 0, "R10 no pulse after one edge", mem_we_o, 0);
    @(posedge clk_i); @(negedge clk_i);
    chk(mem_we_o == 1 && mem_wdata_o == 8'h9E, "R10 pulse after two edges", mem_we_o, 1);
    rw_i = 1'b1; cs_ni = 1'b1;
    wt(4);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule